// File: doc/BRIEF.md
# Priority Winner Selector for Pending Interrupts

This block takes a snapshot of one context's interrupt state and names the source that should be offered next. The state is a pending bit per source ID, a claimed bit per source ID and a latched priority per source ID. The block is purely combinational. It returns the winning ID, the winner's priority and a valid flag. ID 0 is reserved and means that no source is eligible.

A source is eligible when its pending bit is set, its claimed bit is clear, its ID is nonzero and its ID is below the configured source count. Among eligible sources the highest priority wins. The lowest eligible ID is the starting candidate even when its priority is zero. A higher ID takes over only when its priority is strictly greater, so equal priorities go to the lowest ID. The surrounding controller compares the result against a threshold and holds all the storage.

The selection is built as a balanced tree of two-input compare nodes. The number of logic levels grows with the logarithm of the vector width, not with the width itself.

Top module: `prio_pick_sel`

## Requirements
- R1: A source whose claimed bit (claim_i bit i for ID i) is set, or whose pending bit (pend_i bit i) is clear, never wins.
- R2: ID 0 never wins, and no ID at or above NUM_IDS wins, whatever their pending bits and priorities are.
- R3: When no source is eligible, win_vld_o is 0, win_id_o is 0 and win_prio_o is 0.
- R4: An eligible source with priority 0 wins when it is the lowest eligible ID and no other eligible source has a greater priority.
- R5: The winner has the greatest priority among all eligible sources.
- R6: Among eligible sources that share the greatest priority, the lowest ID wins.
- R7: win_prio_o equals the priority of the winning ID, read from prio_i[win_id_o] (4 bits per ID, ID i in element i).
- R8: win_vld_o is 1 exactly when at least one source is eligible, and in that case win_id_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | VEC_W (32) | Pending bit per source ID, bit i for ID i |
| claim_i | input | VEC_W (32) | Claimed (in service) bit per source ID |
| prio_i | input | VEC_W x PRIO_W (32 x 4) | Latched priority per source ID, element i for ID i |
| win_id_o | output | $clog2(VEC_W) (5) | Winning source ID, 0 when none |
| win_prio_o | output | PRIO_W (4) | Priority of the winner, 0 when none |
| win_vld_o | output | 1 | At least one source is eligible |

## Verification
Random pending, claimed and priority vectors exercise the full selection against a sequential scan model. Priorities are sometimes drawn from a narrow range so that ties are frequent, which separates strict from non-strict comparison. Directed patterns cover separate cases. An all-zero input and a fully claimed input show the empty result. A reserved ID 0 pending at top priority shows the exclusion of ID 0. Lone sources at priority 0 show that a zero priority still wins. An all-equal priority field shows that ties go to the lowest ID. A second instance with a reduced source count shows that IDs at or above the limit are excluded while lower ones are still picked.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

    // Default geometry: 31 real sources plus reserved ID 0, 4-bit priorities.
    localparam int DEF_VEC_W   = 32;
    localparam int DEF_NUM_IDS = 32;
    localparam int DEF_PRIO_W  = 4;

    // Number of compare levels for a vector of the given width.
    function automatic int tree_levels(input int width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

    // Leaf count of the balanced tree (next power of two).
    function automatic int tree_leaves(input int width);
        return 1 << tree_levels(width);
    endfunction

endpackage

// File: rtl/prio_elig.sv
module prio_elig #(
    parameter int VEC_W   = prio_sel_pkg::DEF_VEC_W,
    parameter int NUM_IDS = prio_sel_pkg::DEF_NUM_IDS
) (
    input  logic [VEC_W-1:0] pend_i,
    input  logic [VEC_W-1:0] claim_i,
    output logic [VEC_W-1:0] elig_o
);

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        // ID 0 is reserved; IDs at or above NUM_IDS do not exist.
        localparam logic IN_RANGE = (i != 0) && (i < NUM_IDS);
        assign elig_o[i] = pend_i[i] & ~claim_i[i] & IN_RANGE;
    end

endmodule

// File: rtl/prio_node.sv
module prio_node #(
    parameter int ID_W   = 5,
    parameter int PRIO_W = prio_sel_pkg::DEF_PRIO_W
) (
    input  logic              lo_vld,
    input  logic [ID_W-1:0]   lo_id,
    input  logic [PRIO_W-1:0] lo_prio,
    input  logic              hi_vld,
    input  logic [ID_W-1:0]   hi_id,
    input  logic [PRIO_W-1:0] hi_prio,
    output logic              out_vld,
    output logic [ID_W-1:0]   out_id,
    output logic [PRIO_W-1:0] out_prio
);

    logic take_hi;

    // The lower-ID side is kept unless the higher side is valid and
    // strictly more urgent (or the lower side is empty).
    assign take_hi  = hi_vld && (!lo_vld || (hi_prio > lo_prio));
    assign out_vld  = take_hi ? hi_vld  : lo_vld;
    assign out_id   = take_hi ? hi_id   : lo_id;
    assign out_prio = take_hi ? hi_prio : lo_prio;

    always_comb begin
        AST_NODE_VLD_MERGE: assert (out_vld == (lo_vld | hi_vld)) else $error("node valid lost"); // R8
    end

endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
    parameter int VEC_W  = prio_sel_pkg::DEF_VEC_W,
    parameter int PRIO_W = prio_sel_pkg::DEF_PRIO_W,
    localparam int LEVELS = prio_sel_pkg::tree_levels(VEC_W),
    localparam int LEAVES = prio_sel_pkg::tree_leaves(VEC_W),
    localparam int ID_W   = LEVELS
) (
    input  logic [VEC_W-1:0]             elig_i,
    input  logic [VEC_W-1:0][PRIO_W-1:0] prio_i,
    output logic                         root_vld_o,
    output logic [ID_W-1:0]              root_id_o,
    output logic [PRIO_W-1:0]            root_prio_o
);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N = LEAVES >> l;
        logic [N-1:0]             v;
        logic [N-1:0][ID_W-1:0]   id;
        logic [N-1:0][PRIO_W-1:0] pr;

        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < N; j++) begin : g_in
                if (j < VEC_W) begin : g_real
                    assign v[j]  = elig_i[j];
                    assign id[j] = ID_W'(j);
                    assign pr[j] = prio_i[j];
                end else begin : g_pad
                    assign v[j]  = 1'b0;
                    assign id[j] = '0;
                    assign pr[j] = '0;
                end
            end
        end else begin : g_cmp
            for (genvar j = 0; j < N; j++) begin : g_n
                prio_node #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_node (
                    .lo_vld  (g_lvl[l-1].v[2*j]),
                    .lo_id   (g_lvl[l-1].id[2*j]),
                    .lo_prio (g_lvl[l-1].pr[2*j]),
                    .hi_vld  (g_lvl[l-1].v[2*j+1]),
                    .hi_id   (g_lvl[l-1].id[2*j+1]),
                    .hi_prio (g_lvl[l-1].pr[2*j+1]),
                    .out_vld (v[j]),
                    .out_id  (id[j]),
                    .out_prio(pr[j])
                );
            end
        end
    end

    assign root_vld_o  = g_lvl[LEVELS].v[0];
    assign root_id_o   = g_lvl[LEVELS].id[0];
    assign root_prio_o = g_lvl[LEVELS].pr[0];

endmodule

// File: rtl/prio_pick_sel.sv
module prio_pick_sel #(
    parameter int VEC_W   = prio_sel_pkg::DEF_VEC_W,
    parameter int NUM_IDS = prio_sel_pkg::DEF_NUM_IDS,
    parameter int PRIO_W  = prio_sel_pkg::DEF_PRIO_W,
    localparam int ID_W   = prio_sel_pkg::tree_levels(VEC_W)
) (
    input  logic [VEC_W-1:0]             pend_i,
    input  logic [VEC_W-1:0]             claim_i,
    input  logic [VEC_W-1:0][PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]              win_id_o,
    output logic [PRIO_W-1:0]            win_prio_o,
    output logic                         win_vld_o
);

    logic [VEC_W-1:0]  elig;
    logic              root_vld;
    logic [ID_W-1:0]   root_id;
    logic [PRIO_W-1:0] root_prio;

    prio_elig #(.VEC_W(VEC_W), .NUM_IDS(NUM_IDS)) u_elig (
        .pend_i (pend_i),
        .claim_i(claim_i),
        .elig_o (elig)
    );

    prio_tree #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_tree (
        .elig_i     (elig),
        .prio_i     (prio_i),
        .root_vld_o (root_vld),
        .root_id_o  (root_id),
        .root_prio_o(root_prio)
    );

    // Empty result is forced to ID 0 / priority 0.
    assign win_vld_o  = root_vld;
    assign win_id_o   = root_vld ? root_id   : '0;
    assign win_prio_o = root_vld ? root_prio : '0;

    always_comb begin
        AST_VLD_MATCHES_ELIG: assert (win_vld_o == (|elig)) else $error("valid mismatch"); // R8
        AST_EMPTY_IS_ZERO: assert (win_vld_o || (win_id_o == '0 && win_prio_o == '0)) else $error("empty not zero"); // R3
        AST_WIN_NOT_CLAIMED: assert (!win_vld_o || (pend_i[win_id_o] && !claim_i[win_id_o])) else $error("ineligible win"); // R1
        AST_WIN_IN_RANGE: assert (!win_vld_o || (win_id_o != '0 && int'(win_id_o) < NUM_IDS)) else $error("id out of range"); // R2
        AST_WIN_PRIO_TRUE: assert (!win_vld_o || (win_prio_o == prio_i[win_id_o])) else $error("priority mismatch"); // R7
    end

endmodule

// File: tb/test_prio_pick_sel.sv
module test_prio_pick_sel;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 32;
    localparam int PRIO_W     = 4;
    localparam int ID_W       = 5;
    localparam int NARROW_IDS = 20;
    localparam int N_RANDOM   = 10000;

    typedef logic [VEC_W-1:0][PRIO_W-1:0] prio_arr_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic armed = 1'b0;
    logic done = 1'b0;

    logic [VEC_W-1:0] pend  = '0;
    logic [VEC_W-1:0] claim = '0;
    prio_arr_t        prio  = '0;
    string            cur_tag = "R3";

    logic [ID_W-1:0]   w_id,  n_id;
    logic [PRIO_W-1:0] w_pr,  n_pr;
    logic              w_vld, n_vld;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_pick_sel i_prio_pick_sel (
        .pend_i(pend), .claim_i(claim), .prio_i(prio),
        .win_id_o(w_id), .win_prio_o(w_pr), .win_vld_o(w_vld)
    );

    prio_pick_sel #(.NUM_IDS(NARROW_IDS)) i_prio_pick_sel_n20 (
        .pend_i(pend), .claim_i(claim), .prio_i(prio),
        .win_id_o(n_id), .win_prio_o(n_pr), .win_vld_o(n_vld)
    );

    // Sequential scan model straight from the requirements.
    function automatic void ref_pick(input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] c,
                                     input prio_arr_t pr, input int nids,
                                     output int best, output int best_pr);
        best = 0;
        best_pr = 0;
        for (int i = 1; i < nids && i < VEC_W; i++) begin
            if (p[i] && !c[i]) begin
                if (best == 0 || int'(pr[i]) > best_pr) begin
                    best = i;
                    best_pr = int'(pr[i]);
                end
            end
        end
    endfunction

    task automatic compare(input string which, input int nids,
                           input logic [ID_W-1:0] id, input logic [PRIO_W-1:0] pr,
                           input logic vld);
        int e_id, e_pr;
        ref_pick(pend, claim, prio, nids, e_id, e_pr);
        n_checks++;
        if (int'(id) != e_id || int'(pr) != e_pr || vld != (e_id != 0)) begin
            n_fail++;
            $display("FAIL %s %s: id=%0d prio=%0d vld=%0d expected id=%0d prio=%0d vld=%0d",
                     cur_tag, which, id, pr, vld, e_id, e_pr, (e_id != 0));
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            compare("full", 32, w_id, w_pr, w_vld);
            compare("narrow", NARROW_IDS, n_id, n_pr, n_vld);
        end
    end

    task automatic apply(input string tag, input logic [VEC_W-1:0] p,
                         input logic [VEC_W-1:0] c, input prio_arr_t pr);
        @(posedge clk);
        #1;
        cur_tag = tag;
        pend = p;
        claim = c;
        prio = pr;
    endtask

    function automatic prio_arr_t fill_prio(input int v);
        prio_arr_t a;
        for (int i = 0; i < VEC_W; i++) a[i] = PRIO_W'(v);
        return a;
    endfunction

    initial begin
        prio_arr_t pa;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        armed = 1'b1;

        // R3: nothing pending at all.
        apply("R3", '0, '0, '0);
        // R1: everything pending but everything claimed.
        apply("R1", '1, '1, fill_prio(9));
        // R1: claim the most urgent source, next one takes over.
        pa = fill_prio(2); pa[12] = 4'd14; pa[22] = 4'd11;
        apply("R1", 32'h0040_1000 | 32'h0000_0010, 32'h0000_1000, pa);
        // R2: only reserved ID 0 pending at top priority.
        pa = '0; pa[0] = 4'd15;
        apply("R2", 32'h0000_0001, '0, pa);
        // R2: ID 25 wins full instance, narrow instance falls back to ID 3.
        pa = '0; pa[25] = 4'd15; pa[3] = 4'd1;
        apply("R2", (32'd1 << 25) | (32'd1 << 3), '0, pa);
        // R4: lone eligible source at priority 0.
        apply("R4", 32'h0000_0080, '0, '0);
        // R4: two sources at priority 0, lower ID keeps it.
        apply("R4", 32'h0000_0220, '0, '0);
        // R6: all equal priority, all pending.
        apply("R6", '1, '0, fill_prio(6));
        // R6: equal top priority at IDs 9 and 30, below it elsewhere.
        pa = fill_prio(3); pa[9] = 4'd12; pa[30] = 4'd12;
        apply("R6", '1, '0, pa);
        // R5: single strictly higher priority at the top ID.
        pa = fill_prio(8); pa[31] = 4'd9;
        apply("R5", '1, '0, pa);
        // R7: winner priority reported on a sparse pattern.
        pa = '0; pa[17] = 4'd13; pa[4] = 4'd7;
        apply("R7", 32'h0002_0010, '0, pa);

        for (int k = 0; k < N_RANDOM; k++) begin
            int span;
            span = (k % 3 == 0) ? 1 : ((k % 3 == 1) ? 3 : 15);
            for (int i = 0; i < VEC_W; i++) pa[i] = PRIO_W'($urandom_range(0, span));
            apply("R5/R6/R7/R8", $urandom() & $urandom(), $urandom() & $urandom() & $urandom(), pa);
        end

        @(posedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule